// File: doc/BRIEF.md
# Operand-Capturing Issue Queue with Tag Wakeup

This block holds instructions that are waiting to run on one functional unit. A dispatch port writes an instruction into a free slot together with its payload and two source operands. Each operand arrives either as a finished value or, when its producer has not finished yet, as the tag of the physical register that will carry the result. A result bus broadcasts a tag and a value each cycle. Every slot compares the broadcast tag against each of its pending operands, and on a match it stores the value in place of the tag.

A slot whose two operands both hold values can be issued. The queue offers one issuable slot per cycle on its issue port. The slot leaves when the functional unit signals that it can accept work. When several slots are issuable, the one dispatched earliest wins, so slots leave out of program order only when younger work is ready first. Each slot keeps a count of the live slots dispatched after it. This count is the age that ranks slots for selection. A flush input empties the queue in one cycle.

Top module: `wakeup_issue_queue`

## Requirements
- R1: After reset, and in the cycle after any cycle with `flush` high, the queue is empty: `full` is 0 and `iss_valid` is 0. A dispatch offered in a flush cycle is dropped, and `iss_valid` is held at 0 during a flush cycle.
- R2: A dispatch is accepted at a clock edge when `disp_valid` is 1 and `full` is 0. `full` is 1 exactly when all DEPTH slots are occupied. A dispatch offered while `full` is 1 is ignored and creates no entry.
- R3: Operand encoding: when the operand's valid input is 1, its field is a value and is never replaced by a broadcast, even if its low TAG_W bits equal the broadcast tag. When the valid input is 0, the low TAG_W bits of the field are the producer tag and the upper bits are ignored.
- R4: When `bc_valid` is 1 and `bc_tag` equals the tag of a pending operand of an occupied slot, that operand takes `bc_value` and becomes valid at the same edge. Both operands of one slot are captured if both match.
- R5: A broadcast in the same cycle as an accepted dispatch is applied to the operands being written, so a matching pending operand is stored already valid with `bc_value`.
- R6: `iss_valid` is 1 in a cycle if and only if some occupied slot has both operands valid at the start of that cycle (and `flush` is 0). A wakeup therefore makes a slot issuable from the following cycle.
- R7: A slot leaves the queue at an edge where `iss_valid` and `fu_ready` are both 1. While `fu_ready` is 0, the issue outputs keep presenting the same slot.
- R8: Among issuable slots, the one dispatched earliest is presented on the issue port.
- R9: `iss_payload`, `iss_a` and `iss_b` carry the dispatched payload and the captured operand values of the presented slot.
- R10: `full` reflects occupancy at the start of the cycle. When the queue is full, a dispatch in the same cycle as an issue is refused, and the slot freed by the issue accepts a dispatch in the next cycle.
- R11: A broadcast with `bc_valid` at 0, or with a tag that matches no pending operand, changes no slot.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| flush | input | 1 | Empties the queue at the next edge |
| disp_valid | input | 1 | Dispatch request |
| disp_payload | input | PAY_W | Opaque instruction payload |
| disp_a_vld | input | 1 | Operand A holds a value (1) or a tag (0) |
| disp_a_fld | input | DATA_W | Operand A value, or tag in the low TAG_W bits |
| disp_b_vld | input | 1 | Operand B holds a value (1) or a tag (0) |
| disp_b_fld | input | DATA_W | Operand B value, or tag in the low TAG_W bits |
| full | output | 1 | All slots are occupied; dispatch stalls |
| bc_valid | input | 1 | Result broadcast is present |
| bc_tag | input | TAG_W | Tag of the broadcast result |
| bc_value | input | DATA_W | Broadcast result value |
| fu_ready | input | 1 | Functional unit accepts an issue this cycle |
| iss_valid | output | 1 | An issuable slot is presented |
| iss_payload | output | PAY_W | Payload of the presented slot |
| iss_a | output | DATA_W | Operand A value of the presented slot |
| iss_b | output | DATA_W | Operand B value of the presented slot |

## Verification
The embedded properties run on every cycle. They check the following:
- A matching broadcast is captured into a pending operand with the broadcast value.
- A valid operand never changes while its slot is occupied.
- A slot stays occupied until it issues or is flushed.
- A full queue stays full without an issue.
- A flush always empties the queue.
- The age counts of occupied slots stay distinct.
- No issuable slot is older than the one presented.

The bench scenarios are needed for the remaining cases:
- The wakeup of an operand written in the same cycle as its broadcast.
- Dropping a dispatch offered while full.
- Refusing a dispatch in the cycle a full queue issues.
- A valid operand whose low bits alias a broadcast tag.
- End-to-end ordering and operand values against a reference model.

// File: rtl/rsw_pkg.sv
package rsw_pkg;

   // Occupancy view of one slot as seen by the selection logic.
   typedef enum logic [1:0] {
      ST_FREE  = 2'd0,
      ST_WAIT  = 2'd1,
      ST_READY = 2'd2
   } slot_state_e;

   // Number of source operands carried per slot.
   localparam int NUM_SRC = 2;

endpackage

// File: rtl/rsw_slot.sv
module rsw_slot
   import rsw_pkg::*;
#(
   parameter int DATA_W = 32,
   parameter int TAG_W  = 6,
   parameter int PAY_W  = 12,
   parameter int AGE_W  = 3
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              flush,
   input  logic              wr_en,
   input  logic [PAY_W-1:0]  wr_pay,
   input  logic              wr_a_vld,
   input  logic [DATA_W-1:0] wr_a_fld,
   input  logic              wr_b_vld,
   input  logic [DATA_W-1:0] wr_b_fld,
   input  logic              bc_valid,
   input  logic [TAG_W-1:0]  bc_tag,
   input  logic [DATA_W-1:0] bc_value,
   input  logic              leave,
   input  logic              age_inc,
   input  logic              age_dec,
   output slot_state_e       state,
   output logic [AGE_W-1:0]  age,
   output logic [PAY_W-1:0]  pay,
   output logic [DATA_W-1:0] a_fld,
   output logic [DATA_W-1:0] b_fld
);

   logic                busy_q;
   logic                wr_vld [NUM_SRC];
   logic [DATA_W-1:0]   wr_fld [NUM_SRC];
   logic                op_vld [NUM_SRC];
   logic [DATA_W-1:0]   op_fld [NUM_SRC];

   assign wr_vld[0] = wr_a_vld;
   assign wr_vld[1] = wr_b_vld;
   assign wr_fld[0] = wr_a_fld;
   assign wr_fld[1] = wr_b_fld;

   // Occupancy
   always_ff @(posedge clk) begin
      if (!rst_n)      busy_q <= 1'b0;
      else if (flush)  busy_q <= 1'b0;
      else if (wr_en)  busy_q <= 1'b1;
      else if (leave)  busy_q <= 1'b0;
   end

   // Count of live slots younger than this one
   always_ff @(posedge clk) begin
      if (!rst_n || wr_en)          age <= '0;
      else if (age_inc && !age_dec) age <= age + 1'b1;
      else if (age_dec && !age_inc) age <= age - 1'b1;
   end

   always_ff @(posedge clk) begin
      if (!rst_n)     pay <= '0;
      else if (wr_en) pay <= wr_pay;
   end

   // One capture cell per source operand
   for (genvar k = 0; k < NUM_SRC; k++) begin : g_src
      logic wr_hit;
      logic live_hit;

      assign wr_hit   = bc_valid && !wr_vld[k] && (wr_fld[k][TAG_W-1:0] == bc_tag);
      assign live_hit = busy_q && bc_valid && !op_vld[k] &&
                        (op_fld[k][TAG_W-1:0] == bc_tag);

      always_ff @(posedge clk) begin
         if (!rst_n) begin
            op_vld[k] <= 1'b0;
            op_fld[k] <= '0;
         end else if (wr_en) begin
            op_vld[k] <= wr_vld[k] || wr_hit;
            op_fld[k] <= wr_hit ? bc_value : wr_fld[k];
         end else if (live_hit) begin
            op_vld[k] <= 1'b1;
            op_fld[k] <= bc_value;
         end
      end

      assert_wakeup_capture_R4 : assert property (@(posedge clk) disable iff (!rst_n)
         (busy_q && !op_vld[k] && bc_valid && (op_fld[k][TAG_W-1:0] == bc_tag) && !flush)
         |=> (op_vld[k] && op_fld[k] == $past(bc_value)));

      assert_value_held_R3 : assert property (@(posedge clk) disable iff (!rst_n)
         (busy_q && op_vld[k] && !flush && !leave)
         |=> (op_vld[k] && $stable(op_fld[k])));
   end

   always_comb begin
      if (!busy_q)                  state = ST_FREE;
      else if (op_vld[0] && op_vld[1]) state = ST_READY;
      else                          state = ST_WAIT;
   end

   assign a_fld = op_fld[0];
   assign b_fld = op_fld[1];

   assert_slot_persists_R7 : assert property (@(posedge clk) disable iff (!rst_n)
      (busy_q && !leave && !flush) |=> busy_q);

   assert_write_free_slot_R2 : assert property (@(posedge clk) disable iff (!rst_n)
      wr_en |-> !busy_q);

   assert_leave_only_ready_R7 : assert property (@(posedge clk) disable iff (!rst_n)
      leave |-> (busy_q && op_vld[0] && op_vld[1]));

endmodule

// File: rtl/rsw_free_pick.sv
module rsw_free_pick #(
   parameter int DEPTH = 8
) (
   input  logic [DEPTH-1:0] busy,
   output logic             any_free,
   output logic [DEPTH-1:0] grant
);

   // Lowest-index free slot gets the next dispatch
   always_comb begin
      grant    = '0;
      any_free = 1'b0;
      for (int i = 0; i < DEPTH; i++) begin
         if (!busy[i] && !any_free) begin
            grant[i] = 1'b1;
            any_free = 1'b1;
         end
      end
   end

endmodule

// File: rtl/rsw_age_pick.sv
module rsw_age_pick #(
   parameter int DEPTH = 8,
   parameter int AGE_W = 3,
   parameter int IDX_W = 3
) (
   input  logic [DEPTH-1:0] ready,
   input  logic [AGE_W-1:0] ages [DEPTH],
   output logic             found,
   output logic [IDX_W-1:0] index
);

   logic [AGE_W-1:0] best_age;

   // Oldest ready slot: the one with the most younger live slots
   always_comb begin
      found    = 1'b0;
      index    = '0;
      best_age = '0;
      for (int i = 0; i < DEPTH; i++) begin
         if (ready[i] && (!found || ages[i] > best_age)) begin
            found    = 1'b1;
            index    = IDX_W'(i);
            best_age = ages[i];
         end
      end
   end

endmodule

// File: rtl/wakeup_issue_queue.sv
module wakeup_issue_queue
   import rsw_pkg::*;
#(
   parameter int DEPTH  = 8,
   parameter int DATA_W = 32,
   parameter int TAG_W  = 6,
   parameter int PAY_W  = 12
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              flush,
   input  logic              disp_valid,
   input  logic [PAY_W-1:0]  disp_payload,
   input  logic              disp_a_vld,
   input  logic [DATA_W-1:0] disp_a_fld,
   input  logic              disp_b_vld,
   input  logic [DATA_W-1:0] disp_b_fld,
   output logic              full,
   input  logic              bc_valid,
   input  logic [TAG_W-1:0]  bc_tag,
   input  logic [DATA_W-1:0] bc_value,
   input  logic              fu_ready,
   output logic              iss_valid,
   output logic [PAY_W-1:0]  iss_payload,
   output logic [DATA_W-1:0] iss_a,
   output logic [DATA_W-1:0] iss_b
);

   localparam int AGE_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
   localparam int IDX_W = AGE_W;

   // Elaboration-time parameter checks
   if (DEPTH < 2) begin : g_chk_depth
      $error("wakeup_issue_queue: DEPTH must be at least 2");
   end
   if (TAG_W < 1 || TAG_W > DATA_W) begin : g_chk_tag
      $error("wakeup_issue_queue: TAG_W must lie in 1..DATA_W");
   end
   if (PAY_W < 1) begin : g_chk_pay
      $error("wakeup_issue_queue: PAY_W must be positive");
   end

   slot_state_e       st     [DEPTH];
   logic [AGE_W-1:0]  age_a  [DEPTH];
   logic [PAY_W-1:0]  pay_a  [DEPTH];
   logic [DATA_W-1:0] a_a    [DEPTH];
   logic [DATA_W-1:0] b_a    [DEPTH];
   logic [DEPTH-1:0]  busy_v, ready_v, wr_sel;
   logic              any_free, pick_found, disp_fire, iss_fire;
   logic [IDX_W-1:0]  pick_idx;
   logic [AGE_W-1:0]  iss_age;

   rsw_free_pick #(.DEPTH(DEPTH)) u_free (
      .busy     (busy_v),
      .any_free (any_free),
      .grant    (wr_sel)
   );

   rsw_age_pick #(.DEPTH(DEPTH), .AGE_W(AGE_W), .IDX_W(IDX_W)) u_pick (
      .ready (ready_v),
      .ages  (age_a),
      .found (pick_found),
      .index (pick_idx)
   );

   assign full        = !any_free;
   assign disp_fire   = disp_valid && !full && !flush;
   assign iss_valid   = pick_found && !flush;
   assign iss_fire    = iss_valid && fu_ready;
   assign iss_age     = age_a[pick_idx];
   assign iss_payload = pay_a[pick_idx];
   assign iss_a       = a_a[pick_idx];
   assign iss_b       = b_a[pick_idx];

   for (genvar i = 0; i < DEPTH; i++) begin : g_slot
      logic leave_i, inc_i, dec_i;

      assign busy_v[i]  = (st[i] != ST_FREE);
      assign ready_v[i] = (st[i] == ST_READY);
      assign leave_i    = iss_fire && (pick_idx == IDX_W'(i));
      assign inc_i      = disp_fire && busy_v[i];
      assign dec_i      = iss_fire && busy_v[i] && (age_a[i] > iss_age);

      rsw_slot #(.DATA_W(DATA_W), .TAG_W(TAG_W), .PAY_W(PAY_W), .AGE_W(AGE_W)) u_slot (
         .clk      (clk),
         .rst_n    (rst_n),
         .flush    (flush),
         .wr_en    (disp_fire && wr_sel[i]),
         .wr_pay   (disp_payload),
         .wr_a_vld (disp_a_vld),
         .wr_a_fld (disp_a_fld),
         .wr_b_vld (disp_b_vld),
         .wr_b_fld (disp_b_fld),
         .bc_valid (bc_valid),
         .bc_tag   (bc_tag),
         .bc_value (bc_value),
         .leave    (leave_i),
         .age_inc  (inc_i),
         .age_dec  (dec_i),
         .state    (st[i]),
         .age      (age_a[i]),
         .pay      (pay_a[i]),
         .a_fld    (a_a[i]),
         .b_fld    (b_a[i])
      );

      assert_oldest_first_R8 : assert property (@(posedge clk) disable iff (!rst_n)
         (iss_valid && ready_v[i]) |-> (age_a[i] <= iss_age));

      for (genvar j = i + 1; j < DEPTH; j++) begin : g_pair
         assert_distinct_age_R8 : assert property (@(posedge clk) disable iff (!rst_n)
            (busy_v[i] && busy_v[j]) |-> (age_a[i] != age_a[j]));
      end
   end

   assert_flush_empties_R1 : assert property (@(posedge clk) disable iff (!rst_n)
      flush |=> (!full && !iss_valid));

   assert_full_holds_R2 : assert property (@(posedge clk) disable iff (!rst_n)
      (full && !iss_fire && !flush) |=> full);

   assert_no_issue_in_flush_R1 : assert property (@(posedge clk) disable iff (!rst_n)
      flush |-> !iss_valid);

endmodule

// File: tb/wakeup_issue_queue_bench.sv
`timescale 1ns/1ps
module wakeup_issue_queue_bench;

   localparam int DEPTH  = 8;
   localparam int DATA_W = 32;
   localparam int TAG_W  = 6;
   localparam int PAY_W  = 12;

   logic              clk = 1'b0;
   logic              rst_n, flush, disp_valid, disp_a_vld, disp_b_vld;
   logic [PAY_W-1:0]  disp_payload;
   logic [DATA_W-1:0] disp_a_fld, disp_b_fld;
   logic              full, bc_valid, fu_ready, iss_valid;
   logic [TAG_W-1:0]  bc_tag;
   logic [DATA_W-1:0] bc_value, iss_a, iss_b;
   logic [PAY_W-1:0]  iss_payload;

   wakeup_issue_queue #(.DEPTH(DEPTH), .DATA_W(DATA_W), .TAG_W(TAG_W), .PAY_W(PAY_W))
   u_wakeup_issue_queue (
      .clk(clk), .rst_n(rst_n), .flush(flush),
      .disp_valid(disp_valid), .disp_payload(disp_payload),
      .disp_a_vld(disp_a_vld), .disp_a_fld(disp_a_fld),
      .disp_b_vld(disp_b_vld), .disp_b_fld(disp_b_fld),
      .full(full), .bc_valid(bc_valid), .bc_tag(bc_tag), .bc_value(bc_value),
      .fu_ready(fu_ready), .iss_valid(iss_valid), .iss_payload(iss_payload),
      .iss_a(iss_a), .iss_b(iss_b)
   );

   always #4 clk = ~clk;

   int    n_cmp = 0;
   int    n_bad = 0;
   string phase = "R1 reset";
   int    seq_ctr = 0;
   int    pay_ctr = 1;

   // Reference model of the queue contents
   bit                m_busy [DEPTH];
   int                m_seq  [DEPTH];
   bit                m_av   [DEPTH];
   bit                m_bv   [DEPTH];
   logic [DATA_W-1:0] m_af   [DEPTH];
   logic [DATA_W-1:0] m_bf   [DEPTH];
   logic [PAY_W-1:0]  m_pay  [DEPTH];

   function automatic int model_count();
      int c = 0;
      for (int i = 0; i < DEPTH; i++) if (m_busy[i]) c++;
      return c;
   endfunction

   function automatic int model_oldest();
      int best = -1;
      for (int i = 0; i < DEPTH; i++)
         if (m_busy[i] && m_av[i] && m_bv[i] && (best < 0 || m_seq[i] < m_seq[best]))
            best = i;
      return best;
   endfunction

   function automatic bit hit(logic [DATA_W-1:0] f, logic [TAG_W-1:0] t);
      return f[TAG_W-1:0] == t;
   endfunction

   // Operand field carrying a tag, with random upper bits
   function automatic logic [DATA_W-1:0] tagf(int t);
      logic [DATA_W-1:0] r = $urandom();
      return (r & ~DATA_W'((1 << TAG_W) - 1)) | DATA_W'(t);
   endfunction

   task automatic check(string what, logic [DATA_W-1:0] act, logic [DATA_W-1:0] exp);
      n_cmp++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s / %s: actual=%h expected=%h at %0t", phase, what, act, exp, $time);
      end
   endtask

   task automatic step(input bit dv, input bit av, input logic [DATA_W-1:0] af,
                       input bit bv, input logic [DATA_W-1:0] bf,
                       input bit bcv, input int bct, input logic [DATA_W-1:0] bcval,
                       input bit fr, input bit fl);
      bit exp_full, exp_valid;
      int idx, fidx;
      logic [PAY_W-1:0] pay;
      @(negedge clk);
      pay          = PAY_W'(pay_ctr);
      pay_ctr++;
      disp_valid   = dv;
      disp_payload = pay;
      disp_a_vld   = av;
      disp_a_fld   = af;
      disp_b_vld   = bv;
      disp_b_fld   = bf;
      bc_valid     = bcv;
      bc_tag       = TAG_W'(bct);
      bc_value     = bcval;
      fu_ready     = fr;
      flush        = fl;
      #1;
      exp_full  = (model_count() == DEPTH);
      idx       = model_oldest();
      exp_valid = !fl && (idx >= 0);
      check("R2 full", DATA_W'(full), DATA_W'(exp_full));
      check("R6 iss_valid", DATA_W'(iss_valid), DATA_W'(exp_valid));
      if (exp_valid && iss_valid) begin
         check("R8 payload", DATA_W'(iss_payload), DATA_W'(m_pay[idx]));
         check("R9 operand a", iss_a, m_af[idx]);
         check("R9 operand b", iss_b, m_bf[idx]);
      end
      // advance the model across the coming edge
      fidx = -1;
      for (int i = DEPTH - 1; i >= 0; i--) if (!m_busy[i]) fidx = i;
      if (fl) begin
         for (int i = 0; i < DEPTH; i++) m_busy[i] = 1'b0;
      end else begin
         if (exp_valid && fr) m_busy[idx] = 1'b0;
         if (bcv) begin
            for (int i = 0; i < DEPTH; i++) begin
               if (m_busy[i] && !m_av[i] && hit(m_af[i], TAG_W'(bct))) begin
                  m_av[i] = 1'b1; m_af[i] = bcval;
               end
               if (m_busy[i] && !m_bv[i] && hit(m_bf[i], TAG_W'(bct))) begin
                  m_bv[i] = 1'b1; m_bf[i] = bcval;
               end
            end
         end
         if (dv && !exp_full) begin
            m_busy[fidx] = 1'b1;
            m_seq[fidx]  = seq_ctr++;
            m_pay[fidx]  = pay;
            m_av[fidx]   = av;
            m_af[fidx]   = af;
            m_bv[fidx]   = bv;
            m_bf[fidx]   = bf;
            if (bcv && !av && hit(af, TAG_W'(bct))) begin m_av[fidx] = 1'b1; m_af[fidx] = bcval; end
            if (bcv && !bv && hit(bf, TAG_W'(bct))) begin m_bv[fidx] = 1'b1; m_bf[fidx] = bcval; end
         end
      end
   endtask

   task automatic idle(input bit fr);
      step(0, 0, '0, 0, '0, 0, 0, '0, fr, 0);
   endtask

   task automatic do_flush();
      step(0, 0, '0, 0, '0, 0, 0, '0, 0, 1);
   endtask

   task automatic summary();
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
   endtask

   initial begin
      #(200000 * 8);
      n_bad++;
      $display("FAIL watchdog: run did not finish, actual=hung expected=done");
      summary();
      $finish;
   end

   initial begin
      void'($urandom(32'd2024));
      rst_n = 1'b0; flush = 0; disp_valid = 0; disp_a_vld = 0; disp_b_vld = 0;
      disp_payload = '0; disp_a_fld = '0; disp_b_fld = '0;
      bc_valid = 0; bc_tag = '0; bc_value = '0; fu_ready = 0;
      for (int i = 0; i < DEPTH; i++) m_busy[i] = 1'b0;
      repeat (3) @(posedge clk);
      @(negedge clk);
      rst_n = 1'b1;
      #1;
      check("R1 full after reset", DATA_W'(full), '0);
      check("R1 iss_valid after reset", DATA_W'(iss_valid), '0);

      // R2: fill to capacity, extra dispatch dropped
      phase = "R2 fill";
      for (int i = 0; i < DEPTH; i++) step(1, 0, tagf(5), 1, $urandom(), 0, 0, '0, 0, 0);
      step(1, 1, 32'hDEAD0001, 1, 32'hDEAD0002, 0, 0, '0, 0, 0);
      // R4: one broadcast wakes every waiting slot
      phase = "R4 wakeup all";
      step(0, 0, '0, 0, '0, 1, 5, 32'hCAFE0005, 0, 0);
      phase = "R8 drain order";
      for (int i = 0; i < DEPTH + 2; i++) idle(1);

      // R3: valid operand aliasing the broadcast tag stays untouched
      phase = "R3 alias";
      do_flush();
      step(1, 1, 32'h12345645, 0, tagf(5), 0, 0, '0, 0, 0);
      step(0, 0, '0, 0, '0, 1, 5, 32'h0BAD0BAD, 0, 0);
      idle(0);
      idle(1);

      // R5: broadcast in the dispatch cycle
      phase = "R5 same-cycle wakeup";
      do_flush();
      step(1, 0, tagf(3), 1, 32'h00000777, 1, 3, 32'hABCD0003, 0, 0);
      idle(0);
      phase = "R4 both operands";
      step(1, 0, tagf(9), 0, tagf(9), 0, 0, '0, 1, 0);
      step(0, 0, '0, 0, '0, 1, 9, 32'h99999999, 1, 0);
      idle(1);
      idle(1);

      // R11: non-matching and invalid broadcasts do nothing
      phase = "R11 no effect";
      do_flush();
      step(1, 0, tagf(2), 1, 32'h22, 0, 0, '0, 1, 0);
      step(0, 0, '0, 0, '0, 1, 4, 32'h44444444, 1, 0);
      step(0, 0, '0, 0, '0, 0, 2, 32'h55555555, 1, 0);
      idle(1);
      step(0, 0, '0, 0, '0, 1, 2, 32'h22222222, 1, 0);
      idle(1);

      // R7: held while the unit is busy
      phase = "R7 hold";
      step(1, 1, 32'h70, 1, 32'h71, 0, 0, '0, 0, 0);
      for (int i = 0; i < 3; i++) idle(0);
      idle(1);
      idle(1);

      // R10: issue while full does not admit a dispatch the same cycle
      phase = "R10 full turnover";
      do_flush();
      for (int i = 0; i < DEPTH; i++) step(1, 1, $urandom(), 1, $urandom(), 0, 0, '0, 0, 0);
      step(1, 1, 32'hA0, 1, 32'hA1, 0, 0, '0, 1, 0);
      step(1, 1, 32'hB0, 1, 32'hB1, 0, 0, '0, 0, 0);
      idle(0);
      for (int i = 0; i < DEPTH + 1; i++) idle(1);

      // R1: flush wins over a dispatch in the same cycle
      phase = "R1 flush";
      step(1, 1, 32'h10, 1, 32'h11, 0, 0, '0, 0, 0);
      step(1, 1, 32'h12, 1, 32'h13, 0, 0, '0, 1, 1);
      idle(1);

      // Constrained random traffic
      phase = "random";
      for (int n = 0; n < 3000; n++) begin
         bit dv, av, bv, bcv, fr, fl;
         dv  = ($urandom_range(99) < 60);
         av  = ($urandom_range(1) == 1);
         bv  = ($urandom_range(1) == 1);
         bcv = ($urandom_range(99) < 45);
         fr  = ($urandom_range(99) < 70);
         fl  = ($urandom_range(199) == 0);
         step(dv, av, av ? DATA_W'($urandom()) : tagf($urandom_range(7)),
              bv, bv ? DATA_W'($urandom()) : tagf($urandom_range(7)),
              bcv, $urandom_range(7), DATA_W'($urandom()), fr, fl);
      end

      summary();
      $finish;
   end

endmodule